// File: doc/BRIEF.md
# Cycle-Steal Display Fetch Controller

This block fetches character words for a text display from memory that it shares with a processor. While the display is switched on and the block has room, it drives an active-low fetch request. The processor answers by pulling an active-low steal line in a later cycle, and during that cycle it places a 16-bit word holding two character bytes on the bus. The block captures that word and withdraws its request.

Every captured word passes through two register stages: a landing register and then a character register. The character register feeds the display through a valid/ready stream. A word is offered on `chr_word` with `chr_valid` high. It is held there unchanged until the display raises `chr_ready` in the same cycle. The consumer may hold `chr_ready` low for as long as it needs. The back-pressure then reaches the fetch request: no new word is requested while the landing register is occupied.

A display-off input stops all fetching. That frees the memory for the processor. While display-off is high, the blanking and in-process outputs follow it.

Top module: `cs_fetch_ctrl`

## Requirements
- R1: While `rst_n` is low, `fetch_req_n` is 1 and `chr_valid` is 0.
- R2: With `disp_off` at 0 and the landing register empty, `fetch_req_n` goes low within two cycles of reset release. It stays low until a grant arrives.
- R3: A rising clock edge that sees `fetch_req_n`=0 and `steal_n`=0 captures `bus_word`. `fetch_req_n` is 1 in the following cycle.
- R4: Two consecutive cycles never both capture a word, so at most every second cycle is stolen.
- R5: `steal_n`=0 while no request is pending has no effect: no word is captured and `chr_valid` stays 0.
- R6: Captured words reach `chr_word` through the landing register and then the character register, in capture order, with none lost or duplicated. A capture never overwrites an occupied landing register.
- R7: While `chr_valid`=1 and `chr_ready`=0, `chr_valid` and `chr_word` stay stable in the next cycle. No request is raised while the landing register is occupied.
- R8: While `disp_off`=1, `fetch_req_n` is 1 from the next cycle on. `blank` and `in_process` equal `disp_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_off | input | 1 | Display off: suppresses fetch requests |
| fetch_req_n | output | 1 | Active-low fetch request to the processor |
| steal_n | input | 1 | Active-low stolen-cycle grant |
| bus_word | input | 16 | Memory word (two character bytes) during the stolen cycle |
| chr_valid | output | 1 | Character register holds a word |
| chr_ready | input | 1 | Display accepts the word |
| chr_word | output | 16 | Character register contents |
| blank | output | 1 | Screen blanking, follows disp_off |
| in_process | output | 1 | Busy indicator, follows disp_off |

## Verification
Two things can happen on the same edge. The display can take the word in the character register while the landing register moves its word into the character register. This is provoked by granting with no lag while `chr_ready` toggles cycle by cycle. The scoreboard judges it by checking that no word is lost, repeated or reordered. A grant can also arrive on the same edge that display-off rises. The bench expects that word to be delivered, and expects no further requests after that edge.

// File: rtl/cs_fetch_pkg.sv
package cs_fetch_pkg;
  typedef enum logic [1:0] {
    RQ_IDLE = 2'd0,
    RQ_WAIT = 2'd1,
    RQ_REST = 2'd2
  } rq_state_t;
endpackage

// File: rtl/cs_req_ctrl.sv
module cs_req_ctrl
  import cs_fetch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic disp_off,
  input  logic slot_free,
  input  logic steal_n,
  output logic fetch_req_n,
  output logic capture
);
  rq_state_t state_q, state_d;

  assign capture     = (state_q == RQ_WAIT) && !steal_n;
  assign fetch_req_n = (state_q != RQ_WAIT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RQ_IDLE: if (!disp_off && slot_free) state_d = RQ_WAIT;
      RQ_WAIT: begin
        if (capture)       state_d = RQ_REST;
        else if (disp_off) state_d = RQ_IDLE;
      end
      RQ_REST: state_d = RQ_IDLE;
      default: state_d = RQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= RQ_IDLE;
    else        state_q <= state_d;
  end

  assert_withdraw_R3: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> fetch_req_n);
  assert_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !capture);
  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    disp_off |=> fetch_req_n);
  assert_raise_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fetch_req_n) |-> $past(slot_free) && !$past(disp_off));
endmodule

// File: rtl/cs_buf2.sv
module cs_buf2 #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [WORD_W-1:0] bus_word,
  output logic              slot_free,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word
);
  logic [WORD_W-1:0] land_q, chr_q;
  logic              land_full, chr_full;
  logic              move;

  assign move      = land_full && (!chr_full || out_ready);
  assign slot_free = !land_full;
  assign out_valid = chr_full;
  assign out_word  = chr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      land_full <= 1'b0;
      land_q    <= '0;
    end else begin
      if (capture) begin
        land_q    <= bus_word;
        land_full <= 1'b1;
      end else if (move) begin
        land_full <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chr_full <= 1'b0;
      chr_q    <= '0;
    end else if (move) begin
      chr_q    <= land_q;
      chr_full <= 1'b1;
    end else if (out_ready) begin
      chr_full <= 1'b0;
    end
  end

  assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !land_full);
  assert_stage_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !land_full) |=> !out_valid);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));
endmodule

// File: rtl/cs_fetch_ctrl.sv
module cs_fetch_ctrl #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_off,
  output logic              fetch_req_n,
  input  logic              steal_n,
  input  logic [WORD_W-1:0] bus_word,
  output logic              chr_valid,
  input  logic              chr_ready,
  output logic [WORD_W-1:0] chr_word,
  output logic              blank,
  output logic              in_process
);
  logic capture;
  logic slot_free;

  cs_req_ctrl u_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .disp_off    (disp_off),
    .slot_free   (slot_free),
    .steal_n     (steal_n),
    .fetch_req_n (fetch_req_n),
    .capture     (capture)
  );

  cs_buf2 #(.WORD_W(WORD_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .bus_word  (bus_word),
    .slot_free (slot_free),
    .out_valid (chr_valid),
    .out_ready (chr_ready),
    .out_word  (chr_word)
  );

  assign blank      = disp_off;
  assign in_process = disp_off;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (fetch_req_n && !chr_valid));
  assert_stray_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req_n && !steal_n && slot_free) |=> slot_free);
endmodule

// File: tb/sim_cs_fetch_ctrl.sv
module sim_cs_fetch_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        disp_off = 1'b0;
  logic        fetch_req_n;
  logic        steal_n = 1'b1;
  logic [15:0] bus_word = '0;
  logic        chr_valid;
  logic        chr_ready = 1'b1;
  logic [15:0] chr_word;
  logic        blank, in_process;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit resp_en = 1'b0;
  bit stray = 1'b0;
  int lag = 0;
  int wcnt = 0;
  logic [15:0] seq = 16'h1000;
  logic [15:0] expq[$];

  always #10 clk = ~clk;

  cs_fetch_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .disp_off(disp_off), .fetch_req_n(fetch_req_n),
    .steal_n(steal_n), .bus_word(bus_word), .chr_valid(chr_valid),
    .chr_ready(chr_ready), .chr_word(chr_word), .blank(blank),
    .in_process(in_process)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Processor responder (driver): pushes every granted word to the scoreboard
  always @(negedge clk) begin
    if (stray) begin
      steal_n  = 1'b0;
      bus_word = 16'hDEAD;
    end else if (resp_en && fetch_req_n == 1'b0 && steal_n == 1'b1) begin
      if (wcnt >= lag) begin
        steal_n  = 1'b0;
        bus_word = seq;
        expq.push_back(seq);
        seq = seq + 16'd1;
        wcnt = 0;
      end else begin
        wcnt++;
      end
    end else begin
      steal_n = 1'b1;
    end
  end

  // Monitor: samples 5 ns before each rising edge
  logic        p_req = 1'b1, p_steal = 1'b1, p_valid = 1'b0, p_ready = 1'b0, p_off = 1'b0;
  logic [15:0] p_word = '0;
  always @(negedge clk) begin
    #5;
    if (rst_n) begin
      if (!p_req && !p_steal)
        chk(fetch_req_n == 1'b1, "R3/R4 withdraw after grant", fetch_req_n, 1);
      if (p_valid && !p_ready) begin
        chk(chr_valid == 1'b1, "R7 valid held", chr_valid, 1);
        chk(chr_word == p_word, "R7 word held", chr_word, p_word);
      end
      if (p_off && disp_off)
        chk(fetch_req_n == 1'b1, "R8 no request while off", fetch_req_n, 1);
      if (chr_valid && chr_ready) begin
        if (expq.size() == 0) chk(1'b0, "R5/R6 unexpected word", chr_word, 0);
        else begin
          logic [15:0] e;
          e = expq.pop_front();
          chk(chr_word == e, "R6 word order", chr_word, e);
        end
      end
    end
    p_req = fetch_req_n; p_steal = steal_n; p_valid = chr_valid;
    p_ready = chr_ready; p_word = chr_word; p_off = disp_off;
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    cyc(4);
    #5;
    chk(fetch_req_n == 1'b1, "R1 req idle in reset", fetch_req_n, 1);
    chk(chr_valid == 1'b0, "R1 no word in reset", chr_valid, 0);
    chk(blank == 1'b0, "R8 blank follows off", blank, 0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(2);
    #5;
    chk(fetch_req_n == 1'b0, "R2 request raised", fetch_req_n, 0);
    cyc(3);
    #5;
    chk(fetch_req_n == 1'b0, "R2 request held", fetch_req_n, 0);
    // streaming, no lag
    resp_en = 1'b1;
    cyc(40);
    // lagging processor, toggling ready
    lag = 2;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      chr_ready = (i % 3) != 0;
    end
    lag = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chr_ready = i[0];
    end
    // back-pressure
    @(negedge clk); chr_ready = 1'b0;
    cyc(20);
    #5;
    chk(fetch_req_n == 1'b1, "R7 no request while full", fetch_req_n, 1);
    chk(chr_valid == 1'b1, "R7 word waiting", chr_valid, 1);
    @(negedge clk); chr_ready = 1'b1;
    cyc(10);
    // display off
    disp_off = 1'b1;
    cyc(2);
    #5;
    chk(fetch_req_n == 1'b1, "R8 request dropped", fetch_req_n, 1);
    chk(blank == 1'b1, "R8 blank", blank, 1);
    chk(in_process == 1'b1, "R8 in_process", in_process, 1);
    cyc(10);
    chk(expq.size() == 0, "R6 drained while off", expq.size(), 0);
    // stray grant with no request
    resp_en = 1'b0;
    @(posedge clk); stray = 1'b1;
    @(posedge clk); stray = 1'b0;
    cyc(5);
    #5;
    chk(chr_valid == 1'b0, "R5 stray grant ignored", chr_valid, 0);
    @(negedge clk);
    disp_off = 1'b0;
    resp_en = 1'b1;
    cyc(30);
    resp_en = 1'b0;
    cyc(10);
    chk(expq.size() == 0, "R6 all words delivered", expq.size(), 0);
    chk(seq > 16'h1020, "R6 enough words moved", seq, 16'h1020);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule